// File: doc/BRIEF.md
# Destination-Tag 2x2 Routing Switch

This block is one switching element of a multistage indirect network. It has two input links and two output links, called left and right. Every link carries a stream of flits using valid, ready and last. The first flit of a packet is the header. The remaining flits are payload, and the final payload flit is the checksum trailer.

The header flit holds two fields. A count field gives how many destination-address bits are still unused. The address field holds those bits, with the most significant one used first. The switch reads the leading remaining address bit and picks an output from it. It then removes that bit from the header and decrements the count. All other flits pass through unchanged. A chain of these switches therefore delivers a packet with its header count at zero.

When both inputs want the same free output, a round-robin choice decides which one goes. An output stays locked to the input it granted until that packet's last flit has passed. The data path is combinational, so a flit that is accepted leaves the switch in the same cycle.

Top module: `bfly_switch`

## Requirements
- R1: When neither input presents a valid flit, both `out_valid` bits and both `in_ready` bits are low. This also holds right after reset.
- R2: The header flit holds the count `n` in bits [LEN_W-1:0] and the address in bits [DATA_W-1:LEN_W]. When `n` > 0, the packet goes to the left output (index 0) if address bit `n-1` is 0, and to the right output (index 1) if that bit is 1.
- R3: When `n` > 0, the forwarded header has count `n-1`. Its address keeps only bits [n-2:0], and every address bit at position `n-1` or above is zero.
- R4: A header with count 0 goes to the left output, and its flit is forwarded unchanged.
- R5: Payload and trailer flits leave on the same output as their header. Their data and last bit are unchanged.
- R6: Two inputs whose packets target different outputs both transfer in the same cycle.
- R7: When two headers compete for a free output, the winner is the input that holds that output's priority. The priority starts at input 0 after reset. After each header passes an output, that output's priority moves to the other input. The losing input sees `in_ready` low.
- R8: Once a header without last has passed an output, only flits from that same input appear on that output until a flit with last has passed. Packets never interleave.
- R9: Every input transfer produces exactly one output transfer, and no output transfer occurs without an input transfer. A low `out_ready` on the selected output holds `in_ready` low for that input.
- R10: A flit that is offered on an input whose selected output is granted and ready appears on that output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Flit valid, one bit per input link |
| in_data | input | 2 x DATA_W | Flit data per input link |
| in_last | input | 2 | Final flit of the packet, per input link |
| in_ready | output | 2 | Switch accepts the flit, per input link |
| out_valid | output | 2 | Flit valid; index 0 is left, index 1 is right |
| out_data | output | 2 x DATA_W | Flit data per output link |
| out_last | output | 2 | Final flit of the packet, per output link |
| out_ready | input | 2 | Downstream accepts the flit, per output link |

## Verification
The bench targets headers whose count is 0 or whose leading bit is the top bit of a three-bit address. A design with an off-by-one in the bit index would send those packets to the wrong link, or would leave a stale upper address bit in the rewritten header. Contention tests run after several earlier headers have moved each output's priority. An arbiter that fixed the priority, or that rotated it on every flit, would pick the wrong winner. Long packets under random backpressure, competing with a second input, would expose a lock released early: the monitor would see foreign flits inside a packet, or a new header on a busy output. Single-flit packets check that a header which is also last does not leave the output locked.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned NUM_LINKS = 2;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/bfly_in_frame.sv
// Per-input packet framing: tracks header position and the output chosen by it.
module bfly_in_frame
  import bfly_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic              last,
  input  logic              xfer,
  output logic              is_head,
  output side_e             route,
  output logic [1:0]        req
);
  localparam int unsigned ADDR_W = DATA_W - LEN_W;

  logic              at_head_q, at_head_d;
  side_e             route_q, route_d;
  side_e             head_route;
  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] shifted;

  assign cnt  = data[LEN_W-1:0];
  assign addr = data[DATA_W-1:LEN_W];

  // leading remaining address bit decides the side
  always_comb begin
    shifted    = addr >> (cnt - LEN_W'(1));
    head_route = SIDE_LEFT;
    if (cnt != '0) begin
      head_route = shifted[0] ? SIDE_RIGHT : SIDE_LEFT;
    end
  end

  always_comb begin
    at_head_d = at_head_q;
    route_d   = route_q;
    if (xfer) begin
      at_head_d = last;
      if (at_head_q) begin
        route_d = head_route;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_head_q <= 1'b1;
      route_q   <= SIDE_LEFT;
    end else if (xfer) begin
      at_head_q <= at_head_d;
      route_q   <= route_d;
    end
  end

  assign is_head = at_head_q;
  assign route   = at_head_q ? head_route : route_q;
  assign req[0]  = vld & (route == SIDE_LEFT);
  assign req[1]  = vld & (route == SIDE_RIGHT);
endmodule

// File: rtl/bfly_hdr_strip.sv
// Removes the consumed address bit from a header flit; other flits pass as is.
module bfly_hdr_strip #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input  logic              is_head,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned ADDR_W = DATA_W - LEN_W;

  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  cnt_next;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] keep_mask;

  assign cnt  = din[LEN_W-1:0];
  assign addr = din[DATA_W-1:LEN_W];

  always_comb begin
    cnt_next  = cnt - LEN_W'(1);
    keep_mask = ~({ADDR_W{1'b1}} << cnt_next);
    dout      = din;
    if (is_head && (cnt != '0)) begin
      dout = {addr & keep_mask, cnt_next};
    end
  end
endmodule

// File: rtl/bfly_rr_arb.sv
// Per-output arbiter: round-robin on headers, locked to the owner until last.
module bfly_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       xfer,
  input  logic       last,
  output logic [1:0] gnt,
  output logic       sel
);
  logic lock_q, lock_d;
  logic owner_q, owner_d;
  logic prio_q, prio_d;

  always_comb begin
    if (lock_q) begin
      sel = owner_q;
    end else if (req[prio_q]) begin
      sel = prio_q;
    end else if (req[!prio_q]) begin
      sel = !prio_q;
    end else begin
      sel = prio_q;
    end
    gnt      = '0;
    gnt[sel] = req[sel];
  end

  always_comb begin
    lock_d  = lock_q;
    owner_d = owner_q;
    prio_d  = prio_q;
    if (xfer) begin
      lock_d  = !last;
      owner_d = sel;
      if (!lock_q) begin
        prio_d = !sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= 1'b0;
      prio_q  <= 1'b0;
    end else if (xfer) begin
      lock_q  <= lock_d;
      owner_q <= owner_d;
      prio_q  <= prio_d;
    end
  end
endmodule

// File: rtl/bfly_switch.sv
// Destination-tag 2x2 switch top.
module bfly_switch
  import bfly_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             in_valid,
  input  logic [1:0][DATA_W-1:0] in_data,
  input  logic [1:0]             in_last,
  output logic [1:0]             in_ready,
  output logic [1:0]             out_valid,
  output logic [1:0][DATA_W-1:0] out_data,
  output logic [1:0]             out_last,
  input  logic [1:0]             out_ready
);
  logic [1:0]             head_q;
  side_e                  route [NUM_LINKS];
  logic [1:0][1:0]        req_in;   // [input][output]
  logic [1:0][1:0]        req_out;  // [output][input]
  logic [1:0][1:0]        gnt_out;  // [output][input]
  logic [1:0]             sel_out;
  logic [1:0]             in_xfer;
  logic [1:0]             out_xfer;
  logic [1:0][DATA_W-1:0] fwd_data;

  for (genvar gi = 0; gi < NUM_LINKS; gi++) begin : g_in
    bfly_in_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (in_valid[gi]),
      .data    (in_data[gi]),
      .last    (in_last[gi]),
      .xfer    (in_xfer[gi]),
      .is_head (head_q[gi]),
      .route   (route[gi]),
      .req     (req_in[gi])
    );

    bfly_hdr_strip #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_strip (
      .is_head (head_q[gi]),
      .din     (in_data[gi]),
      .dout    (fwd_data[gi])
    );

    assign in_xfer[gi] = in_valid[gi] & in_ready[gi];
  end

  always_comb begin
    for (int o = 0; o < NUM_LINKS; o++) begin
      for (int i = 0; i < NUM_LINKS; i++) begin
        req_out[o][i] = req_in[i][o];
      end
    end
  end

  for (genvar go = 0; go < NUM_LINKS; go++) begin : g_out
    bfly_rr_arb u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_out[go]),
      .xfer  (out_xfer[go]),
      .last  (out_last[go]),
      .gnt   (gnt_out[go]),
      .sel   (sel_out[go])
    );

    assign out_valid[go] = |gnt_out[go];
    assign out_data[go]  = fwd_data[sel_out[go]];
    assign out_last[go]  = in_last[sel_out[go]];
    assign out_xfer[go]  = out_valid[go] & out_ready[go];
  end

  always_comb begin
    for (int i = 0; i < NUM_LINKS; i++) begin
      in_ready[i] = gnt_out[route[i]][i] & out_ready[route[i]];
    end
  end
endmodule

// File: rtl/bfly_switch_chk.sv
module bfly_switch_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             in_valid,
  input logic [1:0][DATA_W-1:0] in_data,
  input logic [1:0]             in_last,
  input logic [1:0]             in_ready,
  input logic [1:0]             out_valid,
  input logic [1:0][DATA_W-1:0] out_data,
  input logic [1:0]             out_last,
  input logic [1:0]             out_ready
);
  logic [1:0] mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          mid_q[o] <= !out_last[o];
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == 2'b00) |-> (out_valid == 2'b00 && in_ready == 2'b00)); // R1

  AST_FLIT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid & in_ready) == $countones(out_valid & out_ready)); // R9

  for (genvar o = 0; o < 2; o++) begin : g_chk
    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> (in_valid != 2'b00)); // R10

    AST_HEAD_SHORTENED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mid_q[o] && out_valid[o]) |->
        ((out_data[o][DATA_W-1:LEN_W] >> out_data[o][LEN_W-1:0]) == '0)); // R3

    AST_BODY_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q[o] && out_valid[o] && out_ready[o]) |->
        ((in_valid[0] && in_ready[0] && in_data[0] == out_data[o] && in_last[0] == out_last[o]) ||
         (in_valid[1] && in_ready[1] && in_data[1] == out_data[o] && in_last[1] == out_last[o]))); // R5
  end
endmodule

bind bfly_switch bfly_switch_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_ready (out_ready)
);

// File: tb/bfly_switch_tb.sv
module bfly_switch_tb;
  localparam int DW = 16;
  localparam int LW = 3;

  logic                clk;
  logic                rst_n;
  logic [1:0]          tb_valid;
  logic [1:0][DW-1:0]  tb_data;
  logic [1:0]          tb_last;
  logic [1:0]          in_ready;
  logic [1:0]          out_valid;
  logic [1:0][DW-1:0]  out_data;
  logic [1:0]          out_last;
  logic [1:0]          ordy;

  int total = 0;
  int bad   = 0;
  logic          mon_on = 1'b0;
  logic          rnd_on = 1'b0;
  logic [DW-1:0] exp_d [2];
  logic          exp_r [2];
  logic          exp_h [2];
  logic          busy  [2];
  logic          own   [2];
  logic          bprio [2];
  int            n_in = 0;
  int            n_out = 0;

  bfly_switch #(.DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tb_valid),
    .in_data   (tb_data),
    .in_last   (tb_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (ordy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mk_head(input int n, input int a);
    logic [DW-1:0] w;
    w = '0;
    w[LW-1:0]  = n[LW-1:0];
    w[DW-1:LW] = a[DW-LW-1:0];
    return w;
  endfunction

  function automatic logic [DW-1:0] model_head(input logic [DW-1:0] w);
    int n;
    int a;
    n = int'(w[LW-1:0]);
    a = int'(w[DW-1:LW]);
    if (n == 0) return w;
    return mk_head(n - 1, a % (1 << (n - 1)));
  endfunction

  function automatic logic model_dir(input logic [DW-1:0] w);
    int n;
    int a;
    n = int'(w[LW-1:0]);
    a = int'(w[DW-1:LW]);
    if (n == 0) return 1'b0;
    return ((a >> (n - 1)) & 1) == 1;
  endfunction

  task automatic send_pkt(input int i, input int n, input int a, input int body);
    logic [DW-1:0] w;
    logic          r;
    w = mk_head(n, a);
    r = model_dir(w);
    @(posedge clk); #1;
    for (int k = 0; k <= body; k++) begin
      if (k > 0) w = DW'($urandom);
      tb_data[i]  = w;
      tb_last[i]  = (k == body);
      tb_valid[i] = 1'b1;
      exp_r[i]    = r;
      exp_h[i]    = (k == 0);
      exp_d[i]    = (k == 0) ? model_head(w) : w;
      do @(negedge clk); while (!in_ready[i]);
      @(posedge clk); #1;
    end
    tb_valid[i] = 1'b0;
    tb_last[i]  = 1'b0;
  endtask

  // scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 2; i++) begin
        if (tb_valid[i] && in_ready[i]) begin
          int o;
          o = int'(exp_r[i]);
          n_in++;
          chk(out_valid[o] && ordy[o], exp_h[i] ? "R2" : "R5", {30'd0, out_valid}, 32'(1 << o));
          if (exp_h[i])
            chk(out_data[o] == exp_d[i], (tb_data[i][LW-1:0] == 0) ? "R4" : "R3", out_data[o], exp_d[i]);
          else
            chk(out_data[o] == exp_d[i], "R5", out_data[o], exp_d[i]);
          chk(out_last[o] == tb_last[i], "R5", out_last[o], tb_last[i]);
          if (exp_h[i]) begin
            chk(!busy[o], "R8", busy[o], 0);
            bprio[o] = !i[0];
          end else begin
            chk(busy[o] && own[o] == i[0], "R8", own[o], i);
          end
          busy[o] = !tb_last[i];
          own[o]  = i[0];
        end
      end
      for (int o = 0; o < 2; o++) begin
        if (out_valid[o] && ordy[o]) begin
          logic found;
          found = 1'b0;
          n_out++;
          for (int i = 0; i < 2; i++)
            if (tb_valid[i] && in_ready[i] && int'(exp_r[i]) == o) found = 1'b1;
          chk(found, "R9", 0, 1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic contend(input int o, input int a0, input int a1, input int b0, input int b1);
    logic w;
    w = bprio[o];
    fork
      send_pkt(0, 3, a0, b0);
      send_pkt(1, 3, a1, b1);
      begin
        @(posedge clk); @(negedge clk);
        chk(in_ready == (2'b01 << w), "R7", in_ready, 2'b01 << w);
      end
    join
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_n = 1'b0; tb_valid = '0; tb_last = '0; tb_data = '0; ordy = 2'b11;
    for (int o = 0; o < 2; o++) begin busy[o] = 0; own[o] = 0; bprio[o] = 0; exp_r[o] = 0; exp_h[o] = 0; exp_d[o] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 2'b00, "R1", out_valid, 0);
    chk(in_ready == 2'b00, "R1", in_ready, 0);
    mon_on = 1'b1;

    // R2 destination 2 (010) leaves on the left
    send_pkt(0, 3, 2, 2);
    send_pkt(1, 3, 7, 1);
    // R6 and R10: disjoint outputs move together in the cycle offered
    fork
      send_pkt(0, 3, 2, 1);
      send_pkt(1, 3, 5, 1);
      begin
        @(posedge clk); @(negedge clk);
        chk(in_ready == 2'b11, "R6", in_ready, 2'b11);
        chk(out_valid == 2'b11, "R10", out_valid, 2'b11);
      end
    join
    // R4 empty headers
    send_pkt(0, 0, 0, 1);
    send_pkt(1, 0, 0, 0);
    // R7 contention on both outputs with rotating priority, R8 lock
    contend(0, 1, 3, 3, 2);
    contend(1, 4, 6, 0, 3);
    send_pkt(0, 1, 1, 0);
    contend(1, 5, 7, 2, 2);
    // R9 backpressure holds the input
    ordy = 2'b00;
    fork
      send_pkt(0, 2, 3, 0);
      begin
        @(posedge clk); @(negedge clk);
        chk(in_ready[0] == 1'b0 && out_valid[1] == 1'b1, "R9", {in_ready[0], out_valid[1]}, 2'b01);
        #3 ordy = 2'b11;
      end
    join

    // random phase
    rnd_on = 1'b1;
    fork
      begin
        while (rnd_on) begin @(posedge clk); #1; if (rnd_on) ordy = 2'($urandom); end
      end
      begin
        fork
          for (int p = 0; p < 60; p++) begin
            int n;
            n = $urandom_range(0, 3);
            send_pkt(0, n, (n == 0) ? 0 : $urandom_range(0, (1 << n) - 1), $urandom_range(0, 4));
            repeat ($urandom_range(0, 2)) @(posedge clk);
          end
          for (int p = 0; p < 60; p++) begin
            int n;
            n = $urandom_range(0, 3);
            send_pkt(1, n, (n == 0) ? 0 : $urandom_range(0, (1 << n) - 1), $urandom_range(0, 4));
            repeat ($urandom_range(0, 2)) @(posedge clk);
          end
        join
        rnd_on = 1'b0;
      end
    join
    #1 ordy = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(n_in == n_out, "R9", n_in, n_out);
    chk(!busy[0] && !busy[1], "R8", {busy[0], busy[1]}, 0);
    chk(out_valid == 2'b00, "R1", out_valid, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule